// File: doc/BRIEF.md
# Auxiliary Event Counter Bank

This block holds a bank of 64-bit activity event counters. The number of counters is set by a parameter, up to sixteen. Each counter has its own enable and event inputs and counts on every clock in which both are high. The counters are reached through one register access port. The port takes the full system-register encoding and selects a counter by a 4-bit number. The top bit of that number comes from the low bit of the CRm field, and the low three bits come from op2.

A read from either of the two lowest privilege levels can be given a virtual view: the physical count minus a 64-bit offset held per counter. A global read-as-zero control hides every count from any level below the top one. A write is taken only from the top privilege level, and only while the target counter is disabled. An index beyond the implemented counters is reported as undefined. Trap and permission decisions are made elsewhere and arrive as a single grant input. The per-counter offsets are loaded through a separate offset port.

Top module: `aux_evt_cnt_bank`

## Requirements
- R1: An access takes effect only when its encoding has op0=2'b11, op1=3'b011, CRn=4'b1101 and CRm[3:1]=3'b110. The encoding is packed as acc_enc_i = {op0[1:0], op1[2:0], CRn[3:0], CRm[3:0], op2[2:0]}, and the counter number is {CRm[0], op2}, which is acc_enc_i[3:0]. Any other encoding returns zero read data, raises no flag and changes no counter.
- R2: A counter adds 1 on each rising edge at which its cnt_en_i bit and its evt_i bit are both high. The new value is visible from the following cycle.
- R3: A counter wraps from all-ones to zero. Its ovf_o bit is high for exactly the one cycle that follows the wrapping edge.
- R4: An access with a counter number greater than or equal to IMPL_CNT raises acc_undef_o in the same cycle. It returns zero and changes no counter.
- R5: A write from any level other than TOP_EL raises acc_undef_o in the same cycle and changes nothing.
- R6: A write to a counter whose cnt_en_i bit is high raises acc_werr_o in the same cycle. The write is ignored, and the counter keeps counting normally.
- R7: An accepted write loads acc_wdata_i into the counter at the next rising edge. Write accesses return zero read data.
- R8: A read at TOP_EL returns the physical count, whatever the values of rz_i and voff_en_i.
- R9: While rz_i is high, reads from any level other than TOP_EL return zero.
- R10: When voff_en_i is high and rz_i does not apply, reads from level 0 or level 1 return the count minus that counter's offset, modulo 2^64. Reads from level 2 return the physical count.
- R11: While acc_grant_i is low, an access returns zero read data, raises no flag and writes nothing.
- R12: When off_we_i is high, the offset of counter off_idx_i is loaded at the next edge. An index of IMPL_CNT or above is ignored. Reset clears every offset to zero.
- R13: While rst_ni is low, every counter and every ovf_o bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | IMPL_CNT | Per-counter enable |
| evt_i | input | IMPL_CNT | Per-counter event |
| acc_valid_i | input | 1 | Register access present this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_grant_i | input | 1 | Permission already resolved upstream |
| acc_enc_i | input | 16 | {op0, op1, CRn, CRm, op2} of the access |
| acc_el_i | input | 2 | Privilege level of the access |
| acc_wdata_i | input | CNT_W | Write data |
| rz_i | input | 1 | Global read-as-zero control |
| voff_en_i | input | 1 | Virtual offset view applies |
| off_we_i | input | 1 | Offset load strobe |
| off_idx_i | input | 4 | Offset target counter |
| off_wdata_i | input | CNT_W | Offset value |
| acc_rdata_o | output | CNT_W | Combinational read data |
| acc_undef_o | output | 1 | Access is undefined |
| acc_werr_o | output | 1 | Write hit an enabled counter and was dropped |
| ovf_o | output | IMPL_CNT | Per-counter wrap pulse |

## Verification
The assertions assume that inputs are stable around the rising edge. They also assume that an accepted write and an increment never hit the same counter in the same cycle. The design guarantees this second point itself, because a write is dropped while the counter is enabled. The bench changes every input only at falling edges. To reach the wrap quickly, it loads counters with values close to all-ones while they are disabled. In the random phase, it picks the level, grant, encoding and enables so that undefined, dropped and accepted writes are mixed with every read view.

// File: rtl/aux_cnt_pkg.sv
`timescale 1ns/1ps
package aux_cnt_pkg;
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned NUM_SLOTS = 1 << IDX_W;
  localparam int unsigned ENC_W     = 16;
  localparam int unsigned EL_W      = 2;

  localparam logic [1:0] OP0_SEL    = 2'b11;
  localparam logic [2:0] OP1_SEL    = 3'b011;
  localparam logic [3:0] CRN_SEL    = 4'b1101;
  localparam logic [2:0] CRM_HI_SEL = 3'b110;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } sysreg_enc_t;
endpackage

// File: rtl/aux_acc_decode.sv
`timescale 1ns/1ps
module aux_acc_decode
  import aux_cnt_pkg::*;
#(
  parameter int unsigned    IMPL_CNT = 12,
  parameter logic [EL_W-1:0] TOP_EL  = 2'd3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 write_i,
  input  logic                 grant_i,
  input  logic [ENC_W-1:0]     enc_i,
  input  logic [EL_W-1:0]      el_i,
  input  logic [NUM_SLOTS-1:0] en_all_i,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 undef_o,
  output logic                 werr_o,
  output logic                 wr_ok_o,
  output logic                 rd_ok_o
);
  sysreg_enc_t f;
  logic match, act, idx_bad, lvl_bad, tgt_en;

  assign f       = sysreg_enc_t'(enc_i);
  assign match   = (f.op0 == OP0_SEL) && (f.op1 == OP1_SEL) &&
                   (f.crn == CRN_SEL) && (f.crm[3:1] == CRM_HI_SEL);
  assign idx_o   = {f.crm[0], f.op2};
  assign act     = valid_i & grant_i & match;
  assign idx_bad = (32'(idx_o) >= IMPL_CNT);
  assign lvl_bad = write_i & (el_i != TOP_EL);
  assign tgt_en  = en_all_i[idx_o];

  assign undef_o = act & (idx_bad | lvl_bad);
  assign werr_o  = act & ~undef_o & write_i & tgt_en;
  assign wr_ok_o = act & ~undef_o & write_i & ~tgt_en;
  assign rd_ok_o = act & ~undef_o & ~write_i;

  assert_wr_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok_o || rd_ok_o) |-> (32'(idx_o) < IMPL_CNT));
  assert_wr_top_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_o |-> (el_i == TOP_EL));
  assert_no_grant_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_i |-> !(undef_o || werr_o || wr_ok_o || rd_ok_o));
endmodule

// File: rtl/aux_cnt_slot.sv
`timescale 1ns/1ps
module aux_cnt_slot #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             evt_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_data_i,
  input  logic             off_ld_i,
  input  logic [CNT_W-1:0] off_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] off_o,
  output logic             ovf_o
);
  logic             inc;
  logic [CNT_W-1:0] cnt_q, off_q;
  logic             ovf_q;

  assign inc = en_i & evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (ld_i) begin
        cnt_q <= ld_data_i;
      end else if (inc) begin
        cnt_q <= cnt_q + 1'b1;
        ovf_q <= &cnt_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       off_q <= '0;
    else if (off_ld_i) off_q <= off_data_i;
  end

  assign cnt_o = cnt_q;
  assign off_o = off_q;
  assign ovf_o = ovf_q;

  assert_ld_disabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |-> !en_i);
  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && !ld_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc && !ld_i) |=> $stable(cnt_q));
  assert_wrap_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (cnt_q == '0));
  assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_q == $past(ld_data_i)));
endmodule

// File: rtl/aux_rd_path.sv
`timescale 1ns/1ps
module aux_rd_path
  import aux_cnt_pkg::*;
#(
  parameter int unsigned     CNT_W  = 64,
  parameter logic [EL_W-1:0] TOP_EL = 2'd3
) (
  input  logic             rd_ok_i,
  input  logic [EL_W-1:0]  el_i,
  input  logic             rz_i,
  input  logic             voff_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] off_i,
  output logic [CNT_W-1:0] rdata_o
);
  logic hide, virt;

  assign hide = rz_i & (el_i != TOP_EL);
  assign virt = voff_en_i & (el_i <= 2'd1);

  always_comb begin
    rdata_o = '0;
    if (rd_ok_i && !hide) begin
      rdata_o = virt ? (cnt_i - off_i) : cnt_i;
    end
  end
endmodule

// File: rtl/aux_evt_cnt_bank.sv
`timescale 1ns/1ps
module aux_evt_cnt_bank
  import aux_cnt_pkg::*;
#(
  parameter int unsigned     IMPL_CNT = 12,
  parameter int unsigned     CNT_W    = 64,
  parameter logic [EL_W-1:0] TOP_EL   = 2'd3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IMPL_CNT-1:0] cnt_en_i,
  input  logic [IMPL_CNT-1:0] evt_i,
  input  logic                acc_valid_i,
  input  logic                acc_write_i,
  input  logic                acc_grant_i,
  input  logic [ENC_W-1:0]    acc_enc_i,
  input  logic [EL_W-1:0]     acc_el_i,
  input  logic [CNT_W-1:0]    acc_wdata_i,
  input  logic                rz_i,
  input  logic                voff_en_i,
  input  logic                off_we_i,
  input  logic [IDX_W-1:0]    off_idx_i,
  input  logic [CNT_W-1:0]    off_wdata_i,
  output logic [CNT_W-1:0]    acc_rdata_o,
  output logic                acc_undef_o,
  output logic                acc_werr_o,
  output logic [IMPL_CNT-1:0] ovf_o
);
  logic [NUM_SLOTS-1:0]            en_all;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] cnt_all, off_all;
  logic [IDX_W-1:0]                idx;
  logic                            wr_ok, rd_ok;

  aux_acc_decode #(.IMPL_CNT(IMPL_CNT), .TOP_EL(TOP_EL)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (acc_valid_i),
    .write_i  (acc_write_i),
    .grant_i  (acc_grant_i),
    .enc_i    (acc_enc_i),
    .el_i     (acc_el_i),
    .en_all_i (en_all),
    .idx_o    (idx),
    .undef_o  (acc_undef_o),
    .werr_o   (acc_werr_o),
    .wr_ok_o  (wr_ok),
    .rd_ok_o  (rd_ok)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (s < IMPL_CNT) begin : g_impl
      aux_cnt_slot #(.CNT_W(CNT_W)) u_slot (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (cnt_en_i[s]),
        .evt_i      (evt_i[s]),
        .ld_i       (wr_ok && (idx == IDX_W'(s))),
        .ld_data_i  (acc_wdata_i),
        .off_ld_i   (off_we_i && (off_idx_i == IDX_W'(s))),
        .off_data_i (off_wdata_i),
        .cnt_o      (cnt_all[s]),
        .off_o      (off_all[s]),
        .ovf_o      (ovf_o[s])
      );
      assign en_all[s] = cnt_en_i[s];
    end else begin : g_absent
      assign en_all[s]  = 1'b0;
      assign cnt_all[s] = '0;
      assign off_all[s] = '0;
    end
  end

  aux_rd_path #(.CNT_W(CNT_W), .TOP_EL(TOP_EL)) u_rd (
    .rd_ok_i   (rd_ok),
    .el_i      (acc_el_i),
    .rz_i      (rz_i),
    .voff_en_i (voff_en_i),
    .cnt_i     (cnt_all[idx]),
    .off_i     (off_all[idx]),
    .rdata_o   (acc_rdata_o)
  );

  assert_undef_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_undef_o |-> (acc_rdata_o == '0) && !acc_werr_o);
  assert_rz_hides_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rz_i && acc_el_i != TOP_EL) |-> (acc_rdata_o == '0));
  assert_top_phys_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && acc_el_i == TOP_EL) |-> (acc_rdata_o == cnt_all[idx]));
  assert_wr_no_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_write_i |-> (acc_rdata_o == '0));
  assert_ovf_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o != '0) |-> ($past(cnt_en_i & evt_i) & ovf_o) == ovf_o);
endmodule

// File: tb/aux_evt_cnt_bank_test.sv
`timescale 1ns/1ps
module aux_evt_cnt_bank_test;
  localparam int IMPL = 12;
  localparam logic [1:0] TOPL = 2'd3;
  localparam logic [11:0] ENC_HI = 12'b11_011_1101_110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IMPL-1:0] s_en = '0, s_evt = '0;
  logic s_valid = 0, s_write = 0, s_grant = 0, s_rz = 0, s_vo = 0, s_off_we = 0;
  logic [15:0] s_enc = '0;
  logic [1:0]  s_el = '0;
  logic [63:0] s_wdata = '0, s_off_wdata = '0;
  logic [3:0]  s_off_idx = '0;
  logic [63:0] rdata;
  logic undef, werr;
  logic [IMPL-1:0] ovf;

  logic [63:0] m_cnt [IMPL];
  logic [63:0] m_off [IMPL];
  logic [IMPL-1:0] m_ovf;
  int nvec = 0, nerr = 0;
  string tag_ovr = "";

  always #5 clk = ~clk;

  aux_evt_cnt_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(s_en), .evt_i(s_evt),
    .acc_valid_i(s_valid), .acc_write_i(s_write), .acc_grant_i(s_grant),
    .acc_enc_i(s_enc), .acc_el_i(s_el), .acc_wdata_i(s_wdata),
    .rz_i(s_rz), .voff_en_i(s_vo), .off_we_i(s_off_we), .off_idx_i(s_off_idx),
    .off_wdata_i(s_off_wdata), .acc_rdata_o(rdata), .acc_undef_o(undef),
    .acc_werr_o(werr), .ovf_o(ovf)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(int idx);
    return {ENC_HI, 4'(idx)};
  endfunction

  task automatic acc(bit v, bit w, int idx, logic [1:0] el, logic [63:0] wd = '0);
    s_valid = v; s_write = w; s_enc = enc(idx); s_el = el; s_wdata = wd; s_grant = 1'b1;
  endtask

  task automatic step();
    logic hit, act, und, we, wok;
    int idx;
    logic [63:0] erd;
    string tag;
    logic [IMPL-1:0] nov;
    #1;
    idx = int'(s_enc[3:0]);
    hit = s_valid && (s_enc[15:4] == ENC_HI);
    act = hit && s_grant;
    und = act && (idx >= IMPL || (s_write && s_el != TOPL));
    we  = act && !und && s_write && s_en[idx];
    wok = act && !und && s_write && !s_en[idx];
    erd = '0;
    if (act && !und && !s_write) begin
      if (s_rz && s_el != TOPL) erd = '0;
      else if (s_vo && s_el <= 2'd1) erd = m_cnt[idx] - m_off[idx];
      else erd = m_cnt[idx];
    end
    if (!hit) tag = "R1";
    else if (!s_grant) tag = "R11";
    else if (idx >= IMPL) tag = "R4";
    else if (s_write) tag = (s_el != TOPL) ? "R5" : (s_en[idx] ? "R6" : "R7");
    else if (s_rz && s_el != TOPL) tag = "R9";
    else if (s_vo && s_el <= 2'd1) tag = "R10";
    else tag = "R8";
    if (tag_ovr != "") tag = tag_ovr;
    chk(tag, "rdata", rdata, erd);
    chk(tag, "undef", 64'(undef), 64'(und));
    chk(tag, "werr", 64'(werr), 64'(we));
    nov = '0;
    for (int i = 0; i < IMPL; i++) begin
      if (wok && idx == i) m_cnt[i] = s_wdata;
      else if (s_en[i] && s_evt[i]) begin
        nov[i] = (m_cnt[i] == '1);
        m_cnt[i] = m_cnt[i] + 64'd1;
      end
    end
    if (s_off_we && int'(s_off_idx) < IMPL) m_off[s_off_idx] = s_off_wdata;
    m_ovf = nov;
    @(posedge clk);
    @(negedge clk);
    chk("R3", "ovf", 64'(ovf), 64'(m_ovf));
  endtask

  initial begin : watchdog
    #2000000;
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < IMPL; i++) begin m_cnt[i] = '0; m_off[i] = '0; end
    m_ovf = '0;
    // R13: reset state
    s_en = '1; s_evt = '1;
    acc(1, 0, 0, TOPL);
    repeat (3) @(negedge clk);
    chk("R13", "rdata in reset", rdata, '0);
    chk("R13", "ovf in reset", 64'(ovf), '0);
    s_en = '0; s_evt = '0;
    rst_n = 1'b1;
    @(negedge clk);

    // R12: offsets start at zero, virtual view equals physical
    tag_ovr = "R12";
    acc(1, 0, 3, 2'd0); s_vo = 1; step();
    s_vo = 0;
    // R2: counting
    tag_ovr = "R2";
    s_en[0] = 1; s_evt[0] = 1;
    acc(1, 0, 0, TOPL);
    repeat (5) step();
    s_evt[0] = 0; step();
    s_evt[0] = 1; step();
    s_en = '0; s_evt = '0;
    tag_ovr = "";
    // R1: wrong encoding write must not land
    acc(1, 1, 4, TOPL, 64'h55); s_enc[15:14] = 2'b10; step();
    acc(1, 1, 4, TOPL, 64'h66); s_enc[6:4] = 3'b111; step();
    acc(1, 0, 4, TOPL); step();
    // R11: no grant
    acc(1, 1, 4, TOPL, 64'h77); s_grant = 0; step();
    acc(1, 0, 4, TOPL); step();
    // R4: indices beyond implemented
    for (int k = IMPL; k < 16; k++) begin acc(1, 1, k, TOPL, 64'h99); step(); end
    for (int k = IMPL; k < 16; k++) begin acc(1, 0, k, TOPL); step(); end
    // R5: write from lower levels
    for (int l = 0; l < 3; l++) begin acc(1, 1, 6, 2'(l), 64'h1234); step(); end
    // R6: write to enabled counter
    s_en[7] = 1; s_evt[7] = 1;
    acc(1, 1, 7, TOPL, 64'hABCD); step();
    acc(1, 0, 7, TOPL); step();
    s_en = '0; s_evt = '0;
    // R7: accepted write
    acc(1, 1, 5, TOPL, 64'h0000_0000_0000_1000); step();
    acc(1, 0, 5, TOPL); step();
    // R3: wrap
    acc(1, 1, 2, TOPL, 64'hFFFF_FFFF_FFFF_FFFE); step();
    s_en[2] = 1; s_evt[2] = 1;
    acc(1, 0, 2, TOPL);
    repeat (4) step();
    s_en = '0; s_evt = '0;
    // R10: virtual view, subtraction wraps
    s_off_we = 1; s_off_idx = 5; s_off_wdata = 64'h0000_0000_0000_2000;
    acc(0, 0, 5, TOPL); step();
    s_off_we = 0;
    s_vo = 1;
    for (int l = 0; l < 4; l++) begin acc(1, 0, 5, 2'(l)); step(); end
    // R12: offset load beyond implemented ignored
    s_off_we = 1; s_off_idx = 4'd13; s_off_wdata = 64'hDEAD; acc(0, 0, 0, TOPL); step();
    s_off_we = 0;
    // R9/R8: read-as-zero
    s_rz = 1;
    for (int l = 0; l < 4; l++) begin acc(1, 0, 5, 2'(l)); step(); end
    s_rz = 0; s_vo = 0;

    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r1, r2;
      logic [63:0] w;
      r1 = $urandom; r2 = $urandom;
      w = {$urandom, $urandom};
      if (r1[31:30] == 2'b11) w = 64'hFFFF_FFFF_FFFF_FFF0 | 64'(r1[3:0]);
      s_en = r2[11:0] & {12{r1[29]}};
      s_evt = r2[23:12];
      acc(r1[0], r1[1], int'(r1[5:2]), r1[7:6], w);
      if (r1[10:8] == 3'b000) s_enc[10:7] = 4'b1100;
      s_grant = (r1[13:11] != 3'b000);
      s_rz = (r1[16:14] == 3'b000);
      s_vo = r1[17];
      s_off_we = (r1[20:18] == 3'b000);
      s_off_idx = r2[27:24];
      s_off_wdata = {$urandom, $urandom};
      step();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule